// File: doc/BRIEF.md
# Checksummed Six-Byte Frame Transmitter

This block sends fixed-length protocol frames on an asynchronous serial line. The host presents five payload bytes and pulses `start`. The block captures the bytes and computes a check byte. The check byte is the XOR of a fixed seed and the five payload bytes. The block then sends all six bytes as serial characters. Each character has one start bit, eight data bits, an even parity bit and one stop bit. A baud divider and a character serializer are included inside the block.

The block keeps its own copy of the most recently launched payload. A `resend` pulse sends that payload again byte for byte, whatever value the payload input has at that moment. `busy` marks a frame in progress and `done` marks its end. The end of every frame also reloads a holdoff counter. An external system tick then counts the holdoff down, and higher-level logic uses it to space its next report.

Top module: `sixbyte_frame_tx`

## Requirements
- R1: While reset is held and right after its release, `txd` is 1, `busy` is 0, `done` is 0 and `holdoff` is 0.
- R2: An accepted frame puts exactly six characters on `txd`. The first five carry payload bytes 0 to 4 in that order, with byte k taken from `payload[8k+7:8k]`. The sixth character carries the check byte.
- R3: The check byte equals 0x5A XOR byte0 XOR byte1 XOR byte2 XOR byte3 XOR byte4.
- R4: Each character lasts eleven bit periods of `CLKS_PER_BIT` clocks each. The bits are, in order: a start bit of 0, data bits 0 to 7 (LSB first), a parity bit equal to the XOR of the eight data bits, and a stop bit of 1.
- R5: `busy` goes to 1 on the clock edge that accepts `start` or `resend` and stays at 1 until the frame ends.
- R6: `done` is 1 for exactly one clock, starting at the clock edge that ends the stop bit of the sixth character. `busy` returns to 0 on the same edge.
- R7: A `start` or `resend` pulse that arrives while `busy` is 1 is ignored. The frame in flight keeps its bytes, and no extra frame follows it.
- R8: When idle, `resend` sends the payload of the most recently launched frame unchanged, even if the `payload` input has since changed. If `start` and `resend` arrive on the same clock, `start` wins and the new payload is sent.
- R9: At the end of each frame `holdoff` is loaded with 7. After that it drops by one on each clock where `hold_tick` is 1, until it reaches 0, and then it stays at 0.
- R10: A `resend` before any frame has been launched sends five zero bytes followed by the check byte 0x5A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that launches a frame from `payload` |
| resend | input | 1 | Pulse that sends the last launched payload again |
| payload | input | 40 | Five payload bytes; byte k in bits 8k+7:8k |
| hold_tick | input | 1 | Tick that decrements the holdoff counter |
| txd | output | 1 | Serial line output, idle high |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| holdoff | output | HOLD_W | Post-send holdoff count |

## Verification
The bench receives the serial line itself. It samples every bit twice, at two points inside the bit period, so it catches both a wrong bit period and wrong bit values. A sweep of payloads, including all zeros, all ones and a walking bit, exposes three kinds of error: a check byte built with the wrong seed or from the wrong bytes, a parity of the wrong sense, and bits sent MSB first. All of these show up as byte or parity mismatches.

Several targeted cases cover the control paths:
- Pulses of `start` and `resend` in the middle of a frame test the busy guard. A design that accepts them corrupts the bytes still to be sent or adds a seventh character or a second frame.
- A `resend` after the payload input has changed catches a design that reads the live input instead of its stored copy.
- A `resend` straight after reset catches a stored copy that does not reset to zero.
- The `done` and `holdoff` checks are made on the exact cycle after the final stop bit, so an off-by-one end condition or a wrong reload value fails there.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int PAYLOAD_BYTES = 5;
  localparam int FRAME_BYTES   = PAYLOAD_BYTES + 1;
  localparam int PAYLOAD_W     = PAYLOAD_BYTES * 8;
  localparam int CHAR_BITS     = 11;
  localparam int IDX_W         = $clog2(FRAME_BYTES + 1);

  typedef logic [7:0] byte_t;

  // seeded XOR of all payload bytes
  function automatic byte_t frame_check(input logic [PAYLOAD_W-1:0] p, input byte_t seed);
    byte_t acc;
    acc = seed;
    for (int k = 0; k < PAYLOAD_BYTES; k++) acc = acc ^ p[k*8 +: 8];
    return acc;
  endfunction

  // {stop, even parity, data, start}, bit 0 leaves first
  function automatic logic [CHAR_BITS-1:0] char_word(input byte_t d);
    return {1'b1, ^d, d, 1'b0};
  endfunction
endpackage

// File: rtl/sbf_baud.sv
module sbf_baud #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && !restart && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (restart || !run)   cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sbf_serializer.sv
module sbf_serializer
  import sbf_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t data,
  output logic  ser_busy,
  output logic  ser_done,
  output logic  txd
);
  localparam int BC_W = $clog2(CHAR_BITS + 1);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(CHAR_BITS - 1);

  logic [CHAR_BITS-1:0] sh_q, sh_d;
  logic [BC_W-1:0]      bc_q, bc_d;
  logic                 run_q, run_d;
  logic                 tick;

  sbf_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .restart(load),
    .tick   (tick)
  );

  always_comb begin
    sh_d     = sh_q;
    bc_d     = bc_q;
    run_d    = run_q;
    ser_done = run_q && tick && (bc_q == LAST_BIT);
    if (load) begin
      sh_d  = char_word(data);
      bc_d  = '0;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      sh_d = {1'b1, sh_q[CHAR_BITS-1:1]};
      if (bc_q == LAST_BIT) begin
        run_d = 1'b0;
        bc_d  = '0;
      end else begin
        bc_d = bc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      bc_q  <= '0;
      run_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      bc_q  <= bc_d;
      run_q <= run_d;
    end
  end

  assign txd      = sh_q[0];
  assign ser_busy = run_q;

  // R4
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) load |-> !run_q);
  // R4
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n) ser_done |-> txd);
endmodule

// File: rtl/sbf_frame_ctrl.sv
module sbf_frame_ctrl
  import sbf_pkg::*;
#(
  parameter logic [7:0] SEED        = 8'h5A,
  parameter int         HOLD_RELOAD = 7,
  parameter int         HOLD_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 resend,
  input  logic [PAYLOAD_W-1:0] payload,
  input  logic                 hold_tick,
  input  logic                 ser_busy,
  input  logic                 ser_done,
  output logic                 ser_load,
  output byte_t                ser_byte,
  output logic                 busy,
  output logic                 done,
  output logic [HOLD_W-1:0]    holdoff
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRAME_BYTES);

  logic [PAYLOAD_W-1:0] stage_q, stage_d, last_q, last_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 busy_q, busy_d, done_q, done_d;
  logic [HOLD_W-1:0]    hold_q, hold_d;
  logic                 take_new, take_old, finish;
  byte_t                check_byte;

  assign check_byte = frame_check(stage_q, SEED);
  assign take_new   = start && !busy_q;
  assign take_old   = resend && !start && !busy_q;
  assign finish     = busy_q && (idx_q == IDX_END) && ser_done;
  assign ser_load   = busy_q && (idx_q != IDX_END) && !ser_busy;

  always_comb begin
    ser_byte = check_byte;
    for (int k = 0; k < PAYLOAD_BYTES; k++)
      if (idx_q == IDX_W'(k)) ser_byte = stage_q[k*8 +: 8];
  end

  always_comb begin
    stage_d = stage_q;
    last_d  = last_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    hold_d  = hold_q;
    if (take_new) begin
      stage_d = payload;
      last_d  = payload;
      busy_d  = 1'b1;
      idx_d   = '0;
    end else if (take_old) begin
      stage_d = last_q;
      busy_d  = 1'b1;
      idx_d   = '0;
    end
    if (ser_load) idx_d = idx_q + 1'b1;
    if (finish) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
    if (finish)                        hold_d = HOLD_W'(HOLD_RELOAD);
    else if (hold_tick && hold_q != '0) hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      last_q  <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      stage_q <= stage_d;
      last_q  <= last_d;
      idx_q   <= idx_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      hold_q  <= hold_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign holdoff = hold_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> !busy_q);
  // R9
  hold_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> hold_q == HOLD_W'(HOLD_RELOAD));
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n) idx_q <= IDX_END);
  // R5
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start || resend));
  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(stage_q));
endmodule

// File: rtl/sixbyte_frame_tx.sv
module sixbyte_frame_tx
  import sbf_pkg::*;
#(
  parameter int         CLKS_PER_BIT = 16,
  parameter logic [7:0] SEED         = 8'h5A,
  parameter int         HOLD_RELOAD  = 7,
  parameter int         HOLD_W       = $clog2(HOLD_RELOAD + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 resend,
  input  logic [PAYLOAD_W-1:0] payload,
  input  logic                 hold_tick,
  output logic                 txd,
  output logic                 busy,
  output logic                 done,
  output logic [HOLD_W-1:0]    holdoff
);
  logic  ser_load, ser_busy, ser_done;
  byte_t ser_byte;

  sbf_frame_ctrl #(
    .SEED(SEED), .HOLD_RELOAD(HOLD_RELOAD), .HOLD_W(HOLD_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .resend   (resend),
    .payload  (payload),
    .hold_tick(hold_tick),
    .ser_busy (ser_busy),
    .ser_done (ser_done),
    .ser_load (ser_load),
    .ser_byte (ser_byte),
    .busy     (busy),
    .done     (done),
    .holdoff  (holdoff)
  );

  sbf_serializer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ser_load),
    .data    (ser_byte),
    .ser_busy(ser_busy),
    .ser_done(ser_done),
    .txd     (txd)
  );

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd);
endmodule

// File: tb/sixbyte_frame_tx_bench.sv
module sixbyte_frame_tx_bench;
  localparam int CPB = 4;

  logic        clk, rst_n, start, resend, hold_tick;
  logic [39:0] payload;
  logic        txd, busy, done;
  logic [2:0]  holdoff;
  int          total, bad;
  bit          finished;

  sixbyte_frame_tx #(.CLKS_PER_BIT(CPB)) u_sixbyte_frame_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .resend(resend), .payload(payload),
    .hold_tick(hold_tick), .txd(txd), .busy(busy), .done(done), .holdoff(holdoff)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_check(input logic [39:0] p);
    logic [7:0] a = 8'h5A;
    for (int k = 0; k < 5; k++) a ^= p[k*8 +: 8];
    return a;
  endfunction

  // receive one character; samples at 1.5 and 3.5 clocks into each bit
  task automatic get_char(output logic [7:0] d, input string req);
    logic [21:0] s;
    int wait_n = 0;
    @(negedge clk);
    while (txd !== 1'b0 && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    check(wait_n < 2000, req, "start bit timeout", wait_n, 0);
    for (int j = 0; j < 22; j++) begin
      if (j == 0) @(negedge clk);
      else repeat (2) @(negedge clk);
      s[j] = txd;
    end
    for (int b = 0; b < 8; b++) d[b] = s[2*(b+1)];
    begin
      bit ok = 1'b1;
      for (int b = 0; b < 11; b++) if (s[2*b] !== s[2*b+1]) ok = 1'b0;
      check(ok, "R4", "bit held for full period", s, 0);
    end
    check(s[0] == 1'b0, "R4", "start bit", s[0], 0);
    check(s[18] == ^d, "R4", "even parity bit", s[18], ^d);
    check(s[20] == 1'b1, "R4", "stop bit", s[20], 1);
  endtask

  task automatic get_frame(input logic [39:0] p, input string req);
    logic [7:0] d;
    for (int k = 0; k < 6; k++) begin
      get_char(d, req);
      if (k < 5) check(d == p[k*8 +: 8], req, "payload byte", d, p[k*8 +: 8]);
      else       check(d == exp_check(p), "R3", "check byte", d, exp_check(p));
    end
    @(negedge clk);
    check(done == 1'b1, "R6", "done after last stop", done, 1);
    check(busy == 1'b0, "R6", "busy low with done", busy, 0);
    check(holdoff == 3'd7, "R9", "holdoff reload", holdoff, 7);
    @(negedge clk);
    check(done == 1'b0, "R6", "done one cycle", done, 0);
  endtask

  task automatic launch(input bit s, input bit r, input logic [39:0] p);
    @(negedge clk);
    payload = p; start = s; resend = r;
    @(negedge clk);
    start = 1'b0; resend = 1'b0;
    check(busy == 1'b1, "R5", "busy after accept", busy, 1);
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; start = 0; resend = 0; hold_tick = 0; payload = '0;
    repeat (3) @(negedge clk);
    check(txd == 1 && busy == 0 && done == 0 && holdoff == 0, "R1", "reset state",
          {txd, busy, done, holdoff}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1 && busy == 0 && done == 0 && holdoff == 0, "R1", "after release",
          {txd, busy, done, holdoff}, 6'b100000);

    // R10: resend before any launch
    launch(0, 1, 40'hFF_FFFF_FFFF);
    get_frame(40'h0, "R10");

    // R2 R3 R4 sweep
    for (int i = 0; i < 24; i++) begin
      logic [39:0] p;
      for (int k = 0; k < 5; k++) p[k*8 +: 8] = 8'((i * 37 + k * 91 + 13) ^ (k << (i % 8)));
      if (i == 0) p = '0;
      if (i == 1) p = '1;
      if (i == 2) p = 40'h01_0204_0810;
      if (i == 3) p = 40'h80_4020_1008;
      launch(1, 0, p);
      get_frame(p, "R2");
    end

    // R8: resend repeats last launched payload
    launch(1, 0, 40'h12_3456_789A);
    get_frame(40'h12_3456_789A, "R8");
    launch(0, 1, 40'hDE_ADBE_EF00);
    get_frame(40'h12_3456_789A, "R8");
    launch(1, 1, 40'hC3_5A96_0F71);
    get_frame(40'hC3_5A96_0F71, "R8");
    launch(0, 1, 40'h0);
    get_frame(40'hC3_5A96_0F71, "R8");

    // R7: start and resend in flight are ignored
    launch(1, 0, 40'hA5_0033_CC7E);
    fork
      begin
        repeat (60) @(negedge clk);
        payload = 40'h11_2233_4455; start = 1; resend = 1;
        @(negedge clk);
        start = 0; resend = 0;
        repeat (100) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
      end
    join_none
    get_frame(40'hA5_0033_CC7E, "R7");
    begin
      bit quiet = 1'b1;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (txd !== 1'b1 || busy !== 1'b0) quiet = 1'b0;
      end
      check(quiet, "R7", "no extra frame", quiet, 1);
    end

    // R9 holdoff countdown
    for (int t = 0; t < 3; t++) begin
      @(negedge clk) hold_tick = 1;
      @(negedge clk) hold_tick = 0;
    end
    check(holdoff == 3'd4, "R9", "holdoff after 3 ticks", holdoff, 4);
    for (int t = 0; t < 10; t++) begin
      @(negedge clk) hold_tick = 1;
      @(negedge clk) hold_tick = 0;
    end
    check(holdoff == 3'd0, "R9", "holdoff saturates at 0", holdoff, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "WD", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule